// File: doc/BRIEF.md
# Memory Fill Engine

The engine writes a repeating pixel pattern over a region of memory. Two independent channels share the engine. Each channel has four 32-bit registers: base, limit, pattern and control. Software programs these registers over a simple word-addressed bus with byte enables. A write to a channel's control word that carries the go bit starts a fill. The channel then streams whole 32-bit words to a shared memory write port and reports completion with a one-cycle interrupt pulse.

The base and limit registers count in 8-byte units, so the byte region is `base*8` up to, but not including, `limit*8`. The pattern element is 16, 24 or 32 bits wide. A 24-bit element is packed across words with a rotating byte phase. The region is 8-byte granular and always made of whole words, so every lane is written in every word. A 24-bit fill whose region is not a multiple of three bytes ends on a partial element, and nothing is written past the limit.

The memory port uses valid/ready. A word is transferred on a clock edge where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, the engine holds the word and its address unchanged. Back-pressure may last any number of cycles and no word is lost. When both channels have a word to send, channel 0 wins.

Top module: `memfill_engine`

## Requirements
- R1: Register word address is `{channel, slot}`, with slot 0 = base, 1 = limit, 2 = pattern, 3 = control. A write updates only the byte lanes whose `reg_be` bit is set. Base and limit keep `ADDR_W-3` bits. `reg_rdata` returns the addressed register combinationally. Control reads back bit 0 = busy, bit 8 = 24-bit select, bit 9 = 32-bit select, and all other bits zero.
- R2: A control write starts a fill only when all of these hold: `reg_be[3]` is set, `reg_wdata[0]` is 1, the channel is idle, and base is nonzero. The channel then reads busy from the next cycle. It emits words at byte addresses base*8, base*8+4, ... up to limit*8-4, in ascending order, each with `mem_be` = 4'hF.
- R3: With control bits 8 and 9 both clear, the fill is 16-bit and every word is `{pattern[15:0], pattern[15:0]}`.
- R4: With bit 8 clear and bit 9 set, the fill is 32-bit and every word is the full pattern.
- R5: With bit 8 set, the fill is 24-bit whatever bit 9 holds. Byte offset n from the region start receives pattern[23:16] if n mod 3 = 0, pattern[15:8] if n mod 3 = 1, and pattern[7:0] if n mod 3 = 2. Byte address a+i sits on `mem_data[8i+7:8i]`.
- R6: A start request while base is zero is ignored: no memory write, no interrupt, and busy stays 0. The mode bits of that write are still stored.
- R7: A start with limit <= base (and base nonzero) writes nothing and never shows busy. `irq[c]` pulses in the cycle after the control write.
- R8: On completion, busy reads 0 and `irq[c]` is high for exactly one cycle, namely the cycle after the edge that accepts the channel's last word.
- R9: While a channel is busy, a write to its control word is ignored (mode bits unchanged, no restart). Writes to its other registers are stored but do not alter the running fill.
- R10: A word transfers on an edge with `mem_valid` and `mem_ready` high. While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_addr`, `mem_data` and `mem_be` hold stable into the next cycle.
- R11: When both channels have words pending and no stalled transfer is outstanding, channel 0's word is presented. A stalled transfer keeps its channel until accepted. Each channel fills only its own region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_CH)+2 | Register word address {channel, slot} |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Register write byte lanes |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mem_valid | output | 1 | Memory write word valid |
| mem_ready | input | 1 | Memory accepts the word this edge |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_data | output | 32 | Write data, lane i at address+i |
| mem_be | output | 4 | Write byte lanes |
| irq | output | NUM_CH | Per-channel completion pulse |

## Verification
Reads are combinational, so register values and busy are due in the cycle after the write edge. A started channel presents its first word in the cycle after the start write. Each word is due exactly once per accepting edge. A channel's interrupt is due in the cycle after the edge that accepts its last word, or after the start write when the region is empty. The bench drives inputs 1 ns after a rising edge and samples at the falling edge with a cycle counter. It predicts, for each channel, the cycle in which a request or interrupt must appear and compares the port values in that cycle. Random back-pressure is drawn at each falling edge, and every stalled cycle is checked against the word of the previous cycle.

// File: rtl/memfill_pkg.sv
`timescale 1ns/1ps
package memfill_pkg;

  localparam int WORD_BYTES = 4;

  // Register slot within a channel (low two bits of the word address).
  localparam logic [1:0] SLOT_BASE    = 2'd0;
  localparam logic [1:0] SLOT_LIMIT   = 2'd1;
  localparam logic [1:0] SLOT_PATTERN = 2'd2;
  localparam logic [1:0] SLOT_CTRL    = 2'd3;

  // Control word bit positions.
  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_W24_BIT = 8;
  localparam int CTRL_W32_BIT = 9;

  typedef enum logic [1:0] {
    PAT16 = 2'd0,
    PAT24 = 2'd1,
    PAT32 = 2'd2
  } pat_width_e;

  // The 24-bit select wins over the 32-bit select.
  function automatic pat_width_e width_sel(input logic w24, input logic w32);
    if (w24) return PAT24;
    if (w32) return PAT32;
    return PAT16;
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  lanes);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      r[8*i +: 8] = lanes[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
    end
    return r;
  endfunction

  // (ph + step) mod 3, for ph in 0..2 and step in 0..3.
  function automatic logic [1:0] phase_add(input logic [1:0] ph, input int step);
    logic [2:0] s;
    s = {1'b0, ph} + 3'(step);
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  // Byte k of a 3-byte element: the high byte of the pattern goes first.
  function automatic logic [7:0] tri_byte(input logic [31:0] v, input logic [1:0] k);
    unique case (k)
      2'd0:    return v[23:16];
      2'd1:    return v[15:8];
      default: return v[7:0];
    endcase
  endfunction

  function automatic logic [31:0] pack_word(input pat_width_e w,
                                            input logic [31:0] v,
                                            input logic [1:0]  ph);
    logic [31:0] r;
    unique case (w)
      PAT32:   r = v;
      PAT24: begin
        for (int i = 0; i < 4; i++) begin
          r[8*i +: 8] = tri_byte(v, phase_add(ph, i));
        end
      end
      default: r = {v[15:0], v[15:0]};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/memfill_cfg.sv
`timescale 1ns/1ps
module memfill_cfg
  import memfill_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [1:0]        slot,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  input  logic              busy,
  output logic [31:0]       rdata,
  output logic              go,
  output logic [ADDR_W-1:0] go_base,
  output logic [ADDR_W-1:0] go_limit,
  output logic [31:0]       go_pattern,
  output pat_width_e        go_width
);

  localparam int UNIT_W = ADDR_W - 3;

  logic [UNIT_W-1:0] base_q, limit_q;
  logic [31:0]       pat_q;
  logic              w24_q, w32_q;
  logic              ctrl_wr, w24_nx, w32_nx;
  logic [31:0]       base_ext, limit_ext;

  assign base_ext  = 32'(base_q);
  assign limit_ext = 32'(limit_q);

  assign ctrl_wr = sel_wr && (slot == SLOT_CTRL) && !busy;
  assign w24_nx  = be[1] ? wdata[CTRL_W24_BIT] : w24_q;
  assign w32_nx  = be[1] ? wdata[CTRL_W32_BIT] : w32_q;

  assign go         = ctrl_wr && be[3] && wdata[CTRL_GO_BIT] && (base_q != '0);
  assign go_base    = {base_q, 3'b000};
  assign go_limit   = {limit_q, 3'b000};
  assign go_pattern = pat_q;
  assign go_width   = width_sel(w24_nx, w32_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      pat_q   <= '0;
      w24_q   <= 1'b0;
      w32_q   <= 1'b0;
    end else if (sel_wr) begin
      unique case (slot)
        SLOT_BASE:    base_q  <= UNIT_W'(lane_merge(base_ext, wdata, be));
        SLOT_LIMIT:   limit_q <= UNIT_W'(lane_merge(limit_ext, wdata, be));
        SLOT_PATTERN: pat_q   <= lane_merge(pat_q, wdata, be);
        default: begin
          if (!busy) begin
            w24_q <= w24_nx;
            w32_q <= w32_nx;
          end
        end
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (slot)
      SLOT_BASE:    rdata = base_ext;
      SLOT_LIMIT:   rdata = limit_ext;
      SLOT_PATTERN: rdata = pat_q;
      default: begin
        rdata[CTRL_GO_BIT]  = busy;
        rdata[CTRL_W24_BIT] = w24_q;
        rdata[CTRL_W32_BIT] = w32_q;
      end
    endcase
  end

endmodule

// File: rtl/memfill_walker.sv
`timescale 1ns/1ps
module memfill_walker
  import memfill_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] go_base,
  input  logic [ADDR_W-1:0] go_limit,
  input  logic [31:0]       go_pattern,
  input  pat_width_e        go_width,
  input  logic              take,
  output logic              req,
  output logic [ADDR_W-1:0] waddr,
  output logic [31:0]       wword,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic              busy_q, done_q;
  logic [ADDR_W-1:0] cur_q, lim_q;
  logic [31:0]       pat_q;
  pat_width_e        width_q;
  logic [1:0]        phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cur_q   <= '0;
      lim_q   <= '0;
      pat_q   <= '0;
      width_q <= PAT16;
      phase_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        // Snapshot the whole configuration so later register writes cannot disturb the run.
        if (go_limit > go_base) begin
          busy_q  <= 1'b1;
          cur_q   <= go_base;
          lim_q   <= go_limit;
          pat_q   <= go_pattern;
          width_q <= go_width;
          phase_q <= '0;
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q && take) begin
        if ((lim_q - cur_q) == STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur_q   <= cur_q + STEP;
          // Four bytes further along is one element phase further, modulo three.
          phase_q <= phase_add(phase_q, 1);
        end
      end
    end
  end

  assign req   = busy_q;
  assign busy  = busy_q;
  assign done  = done_q;
  assign waddr = cur_q;
  assign wword = pack_word(width_q, pat_q, phase_q);

endmodule

// File: rtl/memfill_arb.sv
`timescale 1ns/1ps
module memfill_arb #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              mem_ready,
  output logic [NUM_CH-1:0] grant,
  output logic              mem_valid
);

  logic [NUM_CH-1:0] pick, owner_q;
  logic              lock_q;

  // Fixed priority: the lowest-numbered requester wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) pick = NUM_CH'(1) << i;
    end
  end

  // A stalled transfer keeps its owner so the presented word stays put.
  assign grant     = (lock_q ? owner_q : pick) & req;
  assign mem_valid = |grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
    end else begin
      lock_q  <= mem_valid && !mem_ready;
      owner_q <= grant;
    end
  end

endmodule

// File: rtl/memfill_engine.sv
`timescale 1ns/1ps
module memfill_engine
  import memfill_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 32,
  localparam int RA_W  = $clog2(NUM_CH) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic [3:0]        mem_be,
  output logic [NUM_CH-1:0] irq
);

  localparam int CH_W = RA_W - 2;

  logic [CH_W-1:0]   ch_sel;
  logic [1:0]        slot;
  logic [31:0]       ch_rdata [NUM_CH];
  logic [ADDR_W-1:0] ch_addr  [NUM_CH];
  logic [31:0]       ch_word  [NUM_CH];
  logic [NUM_CH-1:0] busy_vec, req_vec, grant_vec;

  assign ch_sel = reg_addr[RA_W-1:2];
  assign slot   = reg_addr[1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic              go;
    logic [ADDR_W-1:0] go_base, go_limit;
    logic [31:0]       go_pattern;
    pat_width_e        go_width;

    memfill_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_wr     (reg_wr && (ch_sel == CH_W'(g))),
      .slot       (slot),
      .wdata      (reg_wdata),
      .be         (reg_be),
      .busy       (busy_vec[g]),
      .rdata      (ch_rdata[g]),
      .go         (go),
      .go_base    (go_base),
      .go_limit   (go_limit),
      .go_pattern (go_pattern),
      .go_width   (go_width)
    );

    memfill_walker #(.ADDR_W(ADDR_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .go_base    (go_base),
      .go_limit   (go_limit),
      .go_pattern (go_pattern),
      .go_width   (go_width),
      .take       (grant_vec[g] && mem_ready),
      .req        (req_vec[g]),
      .waddr      (ch_addr[g]),
      .wword      (ch_word[g]),
      .busy       (busy_vec[g]),
      .done       (irq[g])
    );
  end

  memfill_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_vec),
    .mem_ready (mem_ready),
    .grant     (grant_vec),
    .mem_valid (mem_valid)
  );

  assign reg_rdata = ch_rdata[ch_sel];

  always_comb begin
    mem_addr = '0;
    mem_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant_vec[i]) begin
        mem_addr = mem_addr | ch_addr[i];
        mem_data = mem_data | ch_word[i];
      end
    end
  end

  // Regions are 8-byte granular, so every lane of every word is written.
  assign mem_be = mem_valid ? 4'hF : 4'h0;

endmodule

// File: rtl/memfill_checker.sv
`timescale 1ns/1ps
module memfill_checker #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic [3:0]        mem_be,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] busy
);

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  assert_full_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be == 4'hF));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  assert_valid_from_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (busy != '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assert_irq_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> !busy[c]);

    assert_irq_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[c]) |-> irq[c]);
  end

endmodule

bind memfill_engine memfill_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_be    (mem_be),
  .irq       (irq),
  .busy      (busy_vec)
);

// File: tb/memfill_engine_tb.sv
`timescale 1ns/1ps
module memfill_engine_tb;

  localparam int NUM_CH = 2;
  localparam int ADDR_W = 32;
  localparam int RA_W   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [3:0]        reg_be = '0;
  logic [31:0]       reg_rdata;
  logic              mem_valid;
  logic              mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_data;
  logic [3:0]        mem_be;
  logic [NUM_CH-1:0] irq;

  memfill_engine #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .irq(irq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int mon_fail = 0;
  int cyc = 0;
  int ready_mode = 0;

  bit          active   [NUM_CH];
  int          words    [NUM_CH];
  int          cnt      [NUM_CH];
  int          wmode    [NUM_CH];
  int          req_from [NUM_CH];
  int          last_acc [NUM_CH];
  int          done_cyc [NUM_CH];
  logic [31:0] lo [NUM_CH];
  logic [31:0] hi [NUM_CH];
  logic [31:0] nxt [NUM_CH];
  logic [31:0] pval [NUM_CH];
  logic [31:0] first_w [NUM_CH];
  logic [31:0] last_w [NUM_CH];

  bit          prev_stall = 1'b0;
  logic [31:0] p_addr, p_data;
  logic [3:0]  p_be;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mfail(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    mon_fail++;
    $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  function automatic logic [31:0] exp_word(input int m, input logic [31:0] v,
                                           input logic [31:0] base, input logic [31:0] a);
    logic [31:0] r;
    int off;
    if (m == 16) return {v[15:0], v[15:0]};
    if (m == 32) return v;
    off = int'(a - base);
    for (int i = 0; i < 4; i++) begin
      case ((off + i) % 3)
        0:       r[8*i +: 8] = v[23:16];
        1:       r[8*i +: 8] = v[15:8];
        default: r[8*i +: 8] = v[7:0];
      endcase
    end
    return r;
  endfunction

  // Monitor: choose this cycle's ready, then judge the presented word.
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0:       mem_ready = 1'b1;
      1:       mem_ready = 1'($urandom % 2);
      default: mem_ready = 1'b0;
    endcase
    if (rst_n) begin
      if (prev_stall && !(mem_valid && mem_addr == p_addr && mem_data == p_data && mem_be == p_be))
        mfail("R10", "stalled word changed", mem_addr, p_addr);
      for (int c = 0; c < NUM_CH; c++) begin
        if (irq[c]) begin
          if (!active[c]) mfail("R8", $sformatf("unexpected irq ch%0d", c), 1, 0);
          else if (cnt[c] != words[c] || cyc != last_acc[c] + 1)
            mfail("R8", $sformatf("irq timing ch%0d", c), cyc, last_acc[c] + 1);
          active[c] = 1'b0;
          done_cyc[c] = cyc;
        end else if (active[c] && cnt[c] == words[c] && cyc > last_acc[c] + 1) begin
          mfail("R8", $sformatf("missing irq ch%0d", c), 0, 1);
          active[c] = 1'b0;
        end
      end
      if (mem_valid) begin
        int hit;
        hit = -1;
        for (int c = 0; c < NUM_CH; c++)
          if (active[c] && cyc >= req_from[c] && mem_addr >= lo[c] && mem_addr < hi[c]) hit = c;
        if (hit < 0) begin
          mfail("R11", "write outside any active region", mem_addr, 0);
        end else begin
          if (hit == 1 && !prev_stall && active[0] && cyc >= req_from[0] && cnt[0] < words[0])
            mfail("R11", "channel 1 presented while channel 0 pending", mem_addr, nxt[0]);
          if (mem_be != 4'hF) mfail("R2", "byte enables", 32'(mem_be), 32'hF);
          if (mem_addr != nxt[hit]) mfail("R2", "address order", mem_addr, nxt[hit]);
          if (mem_data != exp_word(wmode[hit], pval[hit], lo[hit], mem_addr))
            mfail(wmode[hit] == 16 ? "R3" : (wmode[hit] == 32 ? "R4" : "R5"), "word data",
                  mem_data, exp_word(wmode[hit], pval[hit], lo[hit], mem_addr));
          if (mem_ready) begin
            if (cnt[hit] == 0) first_w[hit] = mem_data;
            last_w[hit] = mem_data;
            nxt[hit] = nxt[hit] + 4;
            cnt[hit] = cnt[hit] + 1;
            if (cnt[hit] == words[hit]) last_acc[hit] = cyc;
          end
        end
      end
      prev_stall = mem_valid && !mem_ready;
      p_addr = mem_addr;
      p_data = mem_data;
      p_be   = mem_be;
    end
  end

  task automatic reg_write(input int ch, input int slot, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = RA_W'(ch * 4 + slot); reg_wdata = d; reg_be = be;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic reg_read(input int ch, input int slot, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = RA_W'(ch * 4 + slot);
    #2 d = reg_rdata;
  endtask

  // Program a channel and write its control word; expectations are set in the same slot.
  task automatic launch(input int ch, input logic [31:0] su, input logic [31:0] eu,
                        input logic [31:0] v, input logic [31:0] ctrl);
    reg_write(ch, 0, su, 4'hF);
    reg_write(ch, 1, eu, 4'hF);
    reg_write(ch, 2, v, 4'hF);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = RA_W'(ch * 4 + 3); reg_wdata = ctrl; reg_be = 4'hF;
    lo[ch]  = su << 3;
    hi[ch]  = eu << 3;
    nxt[ch] = su << 3;
    words[ch] = (hi[ch] > lo[ch]) ? int'((hi[ch] - lo[ch]) / 4) : 0;
    cnt[ch]   = 0;
    pval[ch]  = v;
    wmode[ch] = ctrl[8] ? 24 : (ctrl[9] ? 32 : 16);
    req_from[ch] = cyc + 2;
    last_acc[ch] = cyc + 1;
    active[ch]   = (su != 0) && ctrl[0];
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic wait_done(input int ch, input string req);
    for (int i = 0; i < 4000 && active[ch]; i++) @(posedge clk);
    chk(!active[ch], req, $sformatf("channel %0d finished", ch), 32'(active[ch]), 0);
    chk(cnt[ch] == words[ch], "R2", $sformatf("word count ch%0d", ch), cnt[ch], words[ch]);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired: cycles=%0d expected below 150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd24681357));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    reg_read(0, 0, d); chk(d == 0, "R1", "reset base ch0", d, 0);
    reg_read(1, 3, d); chk(d == 0, "R1", "reset control ch1", d, 0);
    chk(mem_valid == 0 && irq == 0, "R8", "reset outputs idle", {irq, mem_valid}, 0);

    // R1 byte lanes and address width
    reg_write(1, 0, 32'hAABBCCDD, 4'b0101);
    reg_read(1, 0, d); chk(d == 32'h00BB00DD, "R1", "partial lane write", d, 32'h00BB00DD);
    reg_write(1, 0, 32'hFFFFFFFF, 4'b1000);
    reg_read(1, 0, d); chk(d == 32'h1FBB00DD, "R1", "base keeps ADDR_W-3 bits", d, 32'h1FBB00DD);
    reg_write(1, 3, 32'h00000301, 4'b0011);
    reg_read(1, 3, d); chk(d == 32'h300, "R2", "go without lane 3 does not start", d, 32'h300);
    reg_write(1, 3, 32'h00000100, 4'b0010);
    reg_read(1, 3, d); chk(d == 32'h100, "R1", "mode bit readback", d, 32'h100);

    // R3: 16-bit fill on channel 0
    launch(0, 4, 6, 32'hCAFEBEEF, 32'h00000001);
    wait_done(0, "R3");
    chk(first_w[0] == 32'hBEEFBEEF, "R3", "16-bit word", first_w[0], 32'hBEEFBEEF);
    reg_read(0, 3, d); chk(d == 0, "R8", "busy cleared", d, 0);

    // R4: 32-bit fill on channel 1
    launch(1, 300, 303, 32'h01234567, 32'h00000201);
    wait_done(1, "R4");
    chk(last_w[1] == 32'h01234567, "R4", "32-bit word", last_w[1], 32'h01234567);

    // R5: 24-bit with both select bits set, six words
    launch(0, 8, 11, 32'h00AABBCC, 32'h00000301);
    wait_done(0, "R5");
    chk(first_w[0] == 32'hAACCBBAA, "R5", "24-bit first word", first_w[0], 32'hAACCBBAA);
    chk(last_w[0] == 32'hCCBBAACC, "R5", "24-bit last word", last_w[0], 32'hCCBBAACC);

    // R6: base zero ignores the start
    launch(0, 0, 5, 32'h11111111, 32'h00000201);
    repeat (20) @(posedge clk);
    reg_read(0, 3, d); chk(d == 32'h200, "R6", "zero base: idle, mode kept", d, 32'h200);

    // R7: empty and inverted regions
    launch(1, 50, 50, 32'h5, 32'h00000001);
    wait_done(1, "R7");
    launch(1, 60, 40, 32'h5, 32'h00000001);
    wait_done(1, "R7");
    reg_read(1, 3, d); chk(d == 0, "R7", "empty region never busy", d, 0);

    // R9 and R10: stall the port and poke a busy channel
    ready_mode = 2;
    launch(0, 10, 14, 32'hA5A51234, 32'h00000001);
    reg_read(0, 3, d); chk(d == 32'h1, "R2", "busy while running", d, 1);
    reg_write(0, 3, 32'h00000301, 4'hF);
    reg_read(0, 3, d); chk(d == 32'h1, "R9", "control write ignored while busy", d, 1);
    reg_write(0, 2, 32'hDEADBEEF, 4'hF);
    reg_read(0, 2, d); chk(d == 32'hDEADBEEF, "R9", "pattern write stored", d, 32'hDEADBEEF);
    repeat (5) @(posedge clk);
    ready_mode = 1;
    wait_done(0, "R9");
    chk(last_w[0] == 32'h12341234, "R9", "running fill kept old pattern", last_w[0], 32'h12341234);

    // R11: channel 0 overtakes a long channel 1 fill
    ready_mode = 0;
    launch(1, 310, 318, 32'h77777777, 32'h00000201);
    launch(0, 20, 22, 32'h00001111, 32'h00000001);
    wait_done(0, "R11");
    wait_done(1, "R11");
    chk(done_cyc[0] < done_cyc[1], "R11", "channel 0 finished first", done_cyc[0], done_cyc[1]);

    // Random concurrent fills
    for (int it = 0; it < 40; it++) begin
      logic [31:0] s0, s1;
      ready_mode = int'($urandom % 2);
      s0 = 1 + ($urandom % 100);
      s1 = 200 + ($urandom % 100);
      launch(1, s1, s1 + ($urandom % 9), $urandom, (($urandom % 4) << 8) | 1);
      launch(0, s0, s0 + ($urandom % 9), $urandom, (($urandom % 4) << 8) | 1);
      wait_done(0, "R11");
      wait_done(1, "R11");
    end

    repeat (5) @(posedge clk);
    chk(mon_fail == 0, "R2/R5/R10/R11", "monitor failures", mon_fail, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule